// File: doc/BRIEF.md
# Two-Register Opcode-Decoded ALU

This block is an 8-bit execution unit built around two working registers, `a` and `b`, plus a carry flag and a zero flag. On every rising clock edge it decodes a 10-bit opcode and updates the registers and flags. The instruction set covers arithmetic, bitwise logic, shifts, rotates through carry, set and clear, compare, move and swap. The opcode encodings are sparse and fixed. Any code outside that set does nothing.

A load strobe preloads both registers with operands before a sequence of operations. The register contents and the flags are driven straight from flops, so every result appears one clock after the opcode that produced it. A synchronous active-high reset clears all state.

Top module: `opdec_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `reg_a`, `reg_b`, `carry` and `zero` become 0 after that edge, whatever the other inputs are.
- R2: When `load` is high (and `rst` low) at an edge, `reg_a` takes `load_a` and `reg_b` takes `load_b`. Both flags keep their values. `load` overrides any opcode presented in the same cycle.
- R3: ADD (0000000001) writes the low 8 bits of a+b into a and sets carry to bit 8 of the sum. INC (1100000000) does the same for a+1. b and zero are unchanged. For example, 11001101 + 11001101 leaves 10011010 in a with carry 1.
- R4: SUB (0000000010) writes (a-b) mod 256 into a and sets carry to 1 exactly when a < b unsigned (a borrow). b and zero are unchanged.
- R5: AND (0000000101), OR (0000000110) and XOR write a op b into a. XOR is reached through either 0000000111 or 1111101010. b and both flags are unchanged.
- R6: One's complement (0000000011) writes ~a into a. Two's complement (0000000100) writes (256-a) mod 256 into a. b and both flags are unchanged.
- R7: Rotate right through carry (1111111111): a becomes {carry, a[7:1]} and carry becomes the old a[0]. Rotate left through carry (1111111110): a becomes {a[6:0], carry} and carry becomes the old a[7].
- R8: Logical shift right (1111111100) fills bit 7 with 0. Logical shift left (1111111000) fills bit 0 with 0. In both cases carry receives the bit shifted out and b and zero are unchanged.
- R9: Set (1111110000) makes a equal to 11111111. Clear (1111100000) makes a equal to 00000000. b and both flags are unchanged.
- R10: Compare (1111000000) writes neither register. It sets zero to (a == b) and carry to (a < b, unsigned).
- R11: Move (1000000000) copies a into b and leaves a unchanged. Swap (1111111010) exchanges a and b in one cycle. Flags are unchanged for both.
- R12: Every other 10-bit code, including 0000000000, leaves `reg_a`, `reg_b`, `carry` and `zero` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Preload strobe for both registers |
| load_a | input | 8 | Operand loaded into a |
| load_b | input | 8 | Operand loaded into b |
| opcode | input | 10 | Operation code, decoded every cycle |
| reg_a | output | 8 | Register a |
| reg_b | output | 8 | Register b |
| carry | output | 1 | Carry / borrow / shifted-out bit |
| zero | output | 1 | Equality result of the last compare |

## Verification
Both registers and both flags are ports, so a wrong next-state value shows up one clock after the opcode that caused it. The bench checks all four at that point, on every vector. A bad carry can also stay hidden until a later rotate or add consumes it. For that reason, each operation in the sweep follows a load, and the bench model carries its own carry forward so that stale-flag errors surface within a few vectors. The bench also applies every undefined code once, so a decode that aliases onto a real operation is visible immediately as a register change.

// File: rtl/opdec_alu_pkg.sv
package opdec_alu_pkg;

    localparam int OPC_W  = 10;
    localparam int DATA_W = 8;

    // Opcode encodings (fixed, sparse)
    localparam logic [OPC_W-1:0] C_ADD  = 10'b0000000001;
    localparam logic [OPC_W-1:0] C_SUB  = 10'b0000000010;
    localparam logic [OPC_W-1:0] C_ONE  = 10'b0000000011;
    localparam logic [OPC_W-1:0] C_TWO  = 10'b0000000100;
    localparam logic [OPC_W-1:0] C_AND  = 10'b0000000101;
    localparam logic [OPC_W-1:0] C_OR   = 10'b0000000110;
    localparam logic [OPC_W-1:0] C_XOR  = 10'b0000000111;
    localparam logic [OPC_W-1:0] C_XOR2 = 10'b1111101010;
    localparam logic [OPC_W-1:0] C_ROR  = 10'b1111111111;
    localparam logic [OPC_W-1:0] C_ROL  = 10'b1111111110;
    localparam logic [OPC_W-1:0] C_LSR  = 10'b1111111100;
    localparam logic [OPC_W-1:0] C_LSL  = 10'b1111111000;
    localparam logic [OPC_W-1:0] C_SET  = 10'b1111110000;
    localparam logic [OPC_W-1:0] C_CLR  = 10'b1111100000;
    localparam logic [OPC_W-1:0] C_CMP  = 10'b1111000000;
    localparam logic [OPC_W-1:0] C_INC  = 10'b1100000000;
    localparam logic [OPC_W-1:0] C_MOV  = 10'b1000000000;
    localparam logic [OPC_W-1:0] C_SWP  = 10'b1111111010;

    typedef enum logic [4:0] {
        OP_NOP, OP_ADD, OP_SUB, OP_INC, OP_ONE, OP_TWO,
        OP_AND, OP_OR,  OP_XOR, OP_ROR, OP_ROL, OP_LSR,
        OP_LSL, OP_SET, OP_CLR, OP_CMP, OP_MOV, OP_SWP
    } op_e;

    // Which pieces of state an operation writes
    typedef struct packed {
        logic wr_a;
        logic wr_b;
        logic wr_c;
        logic wr_z;
    } wen_t;

    function automatic op_e decode_op(input logic [OPC_W-1:0] code);
        op_e k;
        case (code)
            C_ADD:          k = OP_ADD;
            C_SUB:          k = OP_SUB;
            C_ONE:          k = OP_ONE;
            C_TWO:          k = OP_TWO;
            C_AND:          k = OP_AND;
            C_OR:           k = OP_OR;
            C_XOR, C_XOR2:  k = OP_XOR;
            C_ROR:          k = OP_ROR;
            C_ROL:          k = OP_ROL;
            C_LSR:          k = OP_LSR;
            C_LSL:          k = OP_LSL;
            C_SET:          k = OP_SET;
            C_CLR:          k = OP_CLR;
            C_CMP:          k = OP_CMP;
            C_INC:          k = OP_INC;
            C_MOV:          k = OP_MOV;
            C_SWP:          k = OP_SWP;
            default:        k = OP_NOP;
        endcase
        return k;
    endfunction

    function automatic wen_t write_mask(input op_e k);
        wen_t w;
        w = '0;
        case (k)
            OP_ADD, OP_SUB, OP_INC,
            OP_ROR, OP_ROL, OP_LSR, OP_LSL: begin w.wr_a = 1'b1; w.wr_c = 1'b1; end
            OP_ONE, OP_TWO, OP_AND, OP_OR,
            OP_XOR, OP_SET, OP_CLR:         w.wr_a = 1'b1;
            OP_CMP:                         begin w.wr_c = 1'b1; w.wr_z = 1'b1; end
            OP_MOV:                         w.wr_b = 1'b1;
            OP_SWP:                         begin w.wr_a = 1'b1; w.wr_b = 1'b1; end
            default:                        w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/opdec_alu_decode.sv
module opdec_alu_decode
    import opdec_alu_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic [OW-1:0] opcode,
    output op_e           kind,
    output wen_t          wen
);
    always_comb begin
        kind = decode_op(opcode);
        wen  = write_mask(kind);
    end
endmodule

// File: rtl/opdec_alu_exec.sv
module opdec_alu_exec
    import opdec_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  op_e           kind,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c,
    output logic [DW-1:0] res_a,
    output logic [DW-1:0] res_b,
    output logic          res_c,
    output logic          res_z
);
    localparam int XW = DW + 1;

    logic [XW-1:0] sum_ab;
    logic [XW-1:0] sum_inc;
    logic [XW-1:0] diff_ab;

    always_comb begin
        sum_ab  = {1'b0, a} + {1'b0, b};
        sum_inc = {1'b0, a} + XW'(1);
        diff_ab = {1'b0, a} - {1'b0, b};
    end

    always_comb begin
        res_a = a;
        res_b = b;
        res_c = c;
        res_z = (a == b);
        case (kind)
            OP_ADD: begin res_a = sum_ab[DW-1:0];  res_c = sum_ab[DW];  end
            OP_INC: begin res_a = sum_inc[DW-1:0]; res_c = sum_inc[DW]; end
            OP_SUB: begin res_a = diff_ab[DW-1:0]; res_c = diff_ab[DW]; end
            OP_ONE: res_a = ~a;
            OP_TWO: res_a = (~a) + DW'(1);
            OP_AND: res_a = a & b;
            OP_OR:  res_a = a | b;
            OP_XOR: res_a = a ^ b;
            OP_ROR: begin res_a = {c, a[DW-1:1]};    res_c = a[0];    end
            OP_ROL: begin res_a = {a[DW-2:0], c};    res_c = a[DW-1]; end
            OP_LSR: begin res_a = {1'b0, a[DW-1:1]}; res_c = a[0];    end
            OP_LSL: begin res_a = {a[DW-2:0], 1'b0}; res_c = a[DW-1]; end
            OP_SET: res_a = {DW{1'b1}};
            OP_CLR: res_a = '0;
            OP_CMP: res_c = (a < b);
            OP_MOV: res_b = a;
            OP_SWP: begin res_a = b; res_b = a; end
            default: ;
        endcase
    end
endmodule

// File: rtl/opdec_alu_state.sv
module opdec_alu_state
    import opdec_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_a,
    input  logic [DW-1:0] load_b,
    input  wen_t          wen,
    input  logic [DW-1:0] res_a,
    input  logic [DW-1:0] res_b,
    input  logic          res_c,
    input  logic          res_z,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_q,
    output logic          c_q,
    output logic          z_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= 1'b0;
            z_q <= 1'b0;
        end else if (load) begin
            a_q <= load_a;
            b_q <= load_b;
        end else begin
            if (wen.wr_a) a_q <= res_a;
            if (wen.wr_b) b_q <= res_b;
            if (wen.wr_c) c_q <= res_c;
            if (wen.wr_z) z_q <= res_z;
        end
    end
endmodule

// File: rtl/opdec_alu.sv
module opdec_alu
    import opdec_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_a,
    input  logic [DW-1:0] load_b,
    input  logic [OW-1:0] opcode,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic          carry,
    output logic          zero
);
    op_e           kind;
    wen_t          wen;
    logic [DW-1:0] res_a;
    logic [DW-1:0] res_b;
    logic          res_c;
    logic          res_z;

    opdec_alu_decode #(.OW(OW)) u_dec (
        .opcode (opcode),
        .kind   (kind),
        .wen    (wen)
    );

    opdec_alu_exec #(.DW(DW)) u_exec (
        .kind   (kind),
        .a      (reg_a),
        .b      (reg_b),
        .c      (carry),
        .res_a  (res_a),
        .res_b  (res_b),
        .res_c  (res_c),
        .res_z  (res_z)
    );

    opdec_alu_state #(.DW(DW)) u_state (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .load_a (load_a),
        .load_b (load_b),
        .wen    (wen),
        .res_a  (res_a),
        .res_b  (res_b),
        .res_c  (res_c),
        .res_z  (res_z),
        .a_q    (reg_a),
        .b_q    (reg_b),
        .c_q    (carry),
        .z_q    (zero)
    );
endmodule

// File: rtl/opdec_alu_chk.sv
module opdec_alu_chk
    import opdec_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OW = OPC_W
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic [DW-1:0] load_a,
    input logic [DW-1:0] load_b,
    input logic [OW-1:0] opcode,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] reg_b,
    input logic          carry,
    input logic          zero
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (reg_a == '0 && reg_b == '0 && !carry && !zero));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (reg_a == $past(load_a) && reg_b == $past(load_b)
                  && carry == $past(carry) && zero == $past(zero)));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && opcode == C_ADD) |=>
            ({carry, reg_a} == ({1'b0, $past(reg_a)} + {1'b0, $past(reg_b)})));

    // R10
    cmp_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && opcode == C_CMP) |=>
            ($stable(reg_a) && $stable(reg_b)
             && zero == ($past(reg_a) == $past(reg_b))
             && carry == ($past(reg_a) < $past(reg_b))));

    // R11
    swap_xchg_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && opcode == C_SWP) |=>
            (reg_a == $past(reg_b) && reg_b == $past(reg_a) && $stable(carry)));

    // R12
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && decode_op(opcode) == OP_NOP) |=>
            ($stable(reg_a) && $stable(reg_b) && $stable(carry) && $stable(zero)));
endmodule

bind opdec_alu opdec_alu_chk #(.DW(DW), .OW(OW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .load_a (load_a),
    .load_b (load_b),
    .opcode (opcode),
    .reg_a  (reg_a),
    .reg_b  (reg_b),
    .carry  (carry),
    .zero   (zero)
);

// File: tb/tb_opdec_alu.sv
module tb_opdec_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] load_a = '0;
    logic [7:0] load_b = '0;
    logic [9:0] opcode = '0;
    logic [7:0] reg_a;
    logic [7:0] reg_b;
    logic       carry;
    logic       zero;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    int ma = 0, mb = 0, mc = 0, mz = 0;

    always #2 clk = ~clk;

    opdec_alu dut (
        .clk(clk), .rst(rst), .load(load), .load_a(load_a), .load_b(load_b),
        .opcode(opcode), .reg_a(reg_a), .reg_b(reg_b), .carry(carry), .zero(zero)
    );

    task automatic compare(input string tag);
        vectors++;
        if (reg_a !== 8'(ma) || reg_b !== 8'(mb) || carry !== 1'(mc) || zero !== 1'(mz)) begin
            misses++;
            $display("FAIL %s: got a=%02h b=%02h c=%0d z=%0d expected a=%02h b=%02h c=%0d z=%0d",
                     tag, reg_a, reg_b, carry, zero, ma, mb, mc, mz);
        end
    endtask

    task automatic step(input logic r, input logic ld, input logic [7:0] la,
                        input logic [7:0] lb, input logic [9:0] op);
        @(negedge clk);
        rst = r; load = ld; load_a = la; load_b = lb; opcode = op;
        @(posedge clk);
        #1;
        rst = 1'b0; load = 1'b0; opcode = 10'b0;
    endtask

    task automatic do_load(input int la, input int lb);
        step(1'b0, 1'b1, 8'(la), 8'(lb), 10'b0);
        ma = la; mb = lb;
        compare("R2 load");
    endtask

    // Model of one opcode, from the requirement text
    task automatic model_op(input logic [9:0] op, output string tag);
        int s;
        tag = "R12 undefined";
        case (op)
            10'b0000000001: begin s = ma + mb; ma = s % 256; mc = (s > 255); tag = "R3 add"; end
            10'b1100000000: begin s = ma + 1;  ma = s % 256; mc = (s > 255); tag = "R3 inc"; end
            10'b0000000010: begin mc = (ma < mb); ma = (ma - mb + 256) % 256; tag = "R4 sub"; end
            10'b0000000101: begin ma = ma & mb; tag = "R5 and"; end
            10'b0000000110: begin ma = ma | mb; tag = "R5 or"; end
            10'b0000000111,
            10'b1111101010: begin ma = ma ^ mb; tag = "R5 xor"; end
            10'b0000000011: begin ma = 255 - ma; tag = "R6 ones"; end
            10'b0000000100: begin ma = (256 - ma) % 256; tag = "R6 twos"; end
            10'b1111111111: begin s = ma % 2; ma = ma / 2 + mc * 128; mc = s; tag = "R7 ror"; end
            10'b1111111110: begin s = ma / 128; ma = (ma * 2) % 256 + mc; mc = s; tag = "R7 rol"; end
            10'b1111111100: begin mc = ma % 2; ma = ma / 2; tag = "R8 lsr"; end
            10'b1111111000: begin mc = ma / 128; ma = (ma * 2) % 256; tag = "R8 lsl"; end
            10'b1111110000: begin ma = 255; tag = "R9 set"; end
            10'b1111100000: begin ma = 0; tag = "R9 clr"; end
            10'b1111000000: begin mz = (ma == mb); mc = (ma < mb); tag = "R10 cmp"; end
            10'b1000000000: begin mb = ma; tag = "R11 mov"; end
            10'b1111111010: begin s = ma; ma = mb; mb = s; tag = "R11 swap"; end
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [9:0] op);
        string tag;
        step(1'b0, 1'b0, 8'h00, 8'h00, op);
        model_op(op, tag);
        compare(tag);
    endtask

    logic [9:0] codes [18] = '{
        10'b0000000001, 10'b0000000010, 10'b0000000011, 10'b0000000100,
        10'b0000000101, 10'b0000000110, 10'b0000000111, 10'b1111101010,
        10'b1111111111, 10'b1111111110, 10'b1111111100, 10'b1111111000,
        10'b1111110000, 10'b1111100000, 10'b1111000000, 10'b1100000000,
        10'b1000000000, 10'b1111111010 };

    function automatic bit is_defined(input logic [9:0] c);
        for (int k = 0; k < 18; k++) if (codes[k] == c) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 8'h00, 8'h00, 10'b0);
        ma = 0; mb = 0; mc = 0; mz = 0;
        compare("R1 reset");

        // R3: the worked example, 0xCD + 0xCD
        do_load(8'hCD, 8'hCD);
        do_op(10'b0000000001);

        // R2: load overrides an opcode in the same cycle; flags untouched
        do_load(8'hF0, 8'h20);
        do_op(10'b1111000000);
        step(1'b0, 1'b1, 8'h11, 8'h22, 10'b1111111010);
        ma = 8'h11; mb = 8'h22;
        compare("R2 load priority");

        // Sweep every defined opcode over a grid of operands
        for (int k = 0; k < 18; k++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    do_load(i * 17, (j * 17 + 5 * i) % 256);
                    do_op(codes[k]);
                end

        // R7: rotate chains cover both carry-in values
        do_load(8'h81, 8'h00);
        for (int n = 0; n < 9; n++) do_op(10'b1111111111);
        for (int n = 0; n < 9; n++) do_op(10'b1111111110);

        // R10: equal and less-than corner cases
        do_load(8'h7F, 8'h7F); do_op(10'b1111000000);
        do_load(8'h00, 8'hFF); do_op(10'b1111000000);
        do_load(8'hFF, 8'h00); do_op(10'b1111000000);

        // R12: every undefined code leaves state alone
        do_load(8'h5A, 8'hC3);
        do_op(10'b1111000000);
        for (int c = 0; c < 1024; c++)
            if (!is_defined(10'(c))) do_op(10'(c));

        // R1: reset in mid-run
        do_load(8'hAA, 8'h55);
        step(1'b1, 1'b0, 8'h00, 8'h00, 10'b0000000001);
        ma = 0; mb = 0; mc = 0; mz = 0;
        compare("R1 reset mid-run");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule